// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block is the master side of a shared 16-bit bus on which address and data take turns on the same lines. A host asks for a transfer through a small request port: a start pulse, the first word address, a direction flag, the byte lanes to use, a burst length and the write data for each word. The block then runs one bus cycle per word. Each cycle has one address cycle followed by a data phase. The data phase lasts until the slave signals ready. Word addresses step by two bytes.

Next to the shared lines, the block drives the controls that external transceivers and slaves need. These are a direction indicator, separate inbound and outbound transceiver enables, an active-low data strobe and an active-low byte-lane mask. A single drive-enable output tells the pad ring when these controls and the direction indicator own the pins. A host release input, gated by a configuration bit, cuts a burst short. The word in flight always completes first. One `word_done` pulse per finished word lets the host advance its write data and collect read data.

Top module: `mux_bus_master`

## Requirements
- R1: One cycle after a start is accepted in idle, the block is in an address cycle: `dal_oe`=1, `dal_out` equals the requested address and `bus_das`=1. Each following word of a burst uses the previous address plus 2.
- R2: `bus_rd` is 1 for a read burst and 0 for a write burst. It keeps that value in every cycle from the first address cycle to the end of the last word.
- R3: `bus_xin` is 1 only in data-phase cycles of a read. It is never 1 in a write or in an address cycle, and `dal_oe` is 0 whenever it is 1.
- R4: `bus_xout` and `dal_oe` are 1 in the address cycle of a read, and in both address and data cycles of a write. During write data cycles, `dal_out` carries the `req_wdata` value sampled at the end of that word's address cycle.
- R5: `bus_das` is 0 throughout a data phase and returns to 1 on the clock edge that ends it. On that same edge a read word is captured into `rd_data`, and `word_done` is high for the single following cycle, once per word.
- R6: The data phase lasts exactly as many cycles as it takes to see `bus_ready`=1 at a clock edge. While `bus_ready` is 0 the strobe stays low.
- R7: `bus_bm` = {upper-lane mask, lower-lane mask}, active low. It is the inverse of `req_bytes` = {upper enable, lower enable}: 00 means the whole word, 01 means bits 15:8 only, 10 means bits 7:0 only, 11 means no byte.
- R8: A burst transfers exactly `req_len`+1 words and then returns to idle.
- R9: With `cfg_rel_en`=1, a pulse on `bus_rel` during any cycle of a word lets that word finish and then ends the burst. With `cfg_rel_en`=0, `bus_rel` has no effect and the burst runs its full length.
- R10: `ctl_oe` is 1 exactly while a transfer is in progress. When it is 0, `bus_xin`, `bus_xout` and `dal_oe` are 0.
- R11: A start pulse while a burst is in progress is ignored: the running burst's addresses and word count do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rel_en | input | 1 | Enables the host release input |
| req_start | input | 1 | Start pulse, accepted in idle |
| req_addr | input | 16 | First word address (lower 16 bits) |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_bytes | input | 2 | Lane enables {upper, lower} |
| req_len | input | 8 | Burst length minus one, in words |
| req_wdata | input | 16 | Write data for the current word |
| bus_ready | input | 1 | Slave ready, ends the data phase |
| bus_rel | input | 1 | Host release request |
| dal_in | input | 16 | Bus lines as received |
| dal_out | output | 16 | Value to drive on the bus lines |
| dal_oe | output | 1 | Drive enable for the bus lines |
| ctl_oe | output | 1 | Drive enable for the control pins |
| bus_rd | output | 1 | Direction: 1 = data taken in |
| bus_xin | output | 1 | Inbound transceiver enable |
| bus_xout | output | 1 | Outbound transceiver enable |
| bus_das | output | 1 | Data strobe, low in data phase |
| bus_bm | output | 2 | Active-low byte-lane mask |
| busy | output | 1 | Transfer in progress |
| word_done | output | 1 | One-cycle pulse per completed word |
| rd_data | output | 16 | Last captured read word |

## Verification
Bursts are run as writes and as reads, from one to seven words long. Each burst uses a different lane selection, so every mask code appears, and wait states range from none to three. Varying the wait states separates a correct strobe hold from one that ends on a fixed count. Changing the write data per word shows whether the data is resampled at each address cycle or latched once. The release input is pulsed at a middle word, at the first word and with the configuration bit off. These three cases separate early termination, a lost release and a release that ignores its enable. A start pulse issued mid-burst shows whether a busy block re-arms itself.

// File: rtl/mbm_pkg.sv
package mbm_pkg;
    parameter int unsigned DAL_W = 16;
    parameter int unsigned LEN_W = 8;
    parameter int unsigned BM_W  = 2;
    localparam int unsigned ADDR_STEP = DAL_W / 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA
    } bus_state_e;

    typedef struct packed {
        bus_state_e       st;
        logic [DAL_W-1:0] addr;
        logic             wr;
        logic [BM_W-1:0]  mask;
        logic [LEN_W-1:0] left;
        logic [DAL_W-1:0] wdata;
        logic [DAL_W-1:0] rdata;
        logic             done;
        logic             stop;
    } seq_t;
endpackage

// File: rtl/mbm_seq.sv
module mbm_seq
    import mbm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_rel_en,
    input  logic             req_start,
    input  logic [DAL_W-1:0] req_addr,
    input  logic             req_write,
    input  logic [BM_W-1:0]  req_bytes,
    input  logic [LEN_W-1:0] req_len,
    input  logic [DAL_W-1:0] req_wdata,
    input  logic             bus_ready,
    input  logic             bus_rel,
    input  logic [DAL_W-1:0] dal_in,
    output bus_state_e       st,
    output logic [DAL_W-1:0] cur_addr,
    output logic             cur_wr,
    output logic [BM_W-1:0]  cur_mask,
    output logic [DAL_W-1:0] cur_wdata,
    output logic [DAL_W-1:0] rd_data,
    output logic             word_done
);
    seq_t s_d, s_q;
    logic rel_hit;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        rel_hit  = cfg_rel_en && bus_rel;
        case (s_q.st)
            ST_IDLE: begin
                if (req_start) begin
                    s_d.st   = ST_ADDR;
                    s_d.addr = req_addr;
                    s_d.wr   = req_write;
                    for (int i = 0; i < int'(BM_W); i++) begin
                        s_d.mask[i] = !req_bytes[i];
                    end
                    s_d.left = req_len;
                    s_d.stop = 1'b0;
                end
            end
            ST_ADDR: begin
                s_d.st = ST_DATA;
                if (s_q.wr) s_d.wdata = req_wdata;
                if (rel_hit) s_d.stop = 1'b1;
            end
            ST_DATA: begin
                if (rel_hit) s_d.stop = 1'b1;
                if (bus_ready) begin
                    s_d.done = 1'b1;
                    if (!s_q.wr) s_d.rdata = dal_in;
                    if (s_q.left == '0 || s_q.stop || rel_hit) begin
                        s_d.st = ST_IDLE;
                    end else begin
                        s_d.st   = ST_ADDR;
                        s_d.addr = s_q.addr + DAL_W'(ADDR_STEP);
                        s_d.left = s_q.left - 1'b1;
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= ST_IDLE;
            s_q.mask <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign st        = s_q.st;
    assign cur_addr  = s_q.addr;
    assign cur_wr    = s_q.wr;
    assign cur_mask  = s_q.mask;
    assign cur_wdata = s_q.wdata;
    assign rd_data   = s_q.rdata;
    assign word_done = s_q.done;
endmodule

// File: rtl/mbm_pins.sv
module mbm_pins
    import mbm_pkg::*;
(
    input  bus_state_e       st,
    input  logic [DAL_W-1:0] cur_addr,
    input  logic             cur_wr,
    input  logic [BM_W-1:0]  cur_mask,
    input  logic [DAL_W-1:0] cur_wdata,
    output logic [DAL_W-1:0] dal_out,
    output logic             dal_oe,
    output logic             ctl_oe,
    output logic             bus_rd,
    output logic             bus_xin,
    output logic             bus_xout,
    output logic             bus_das,
    output logic [BM_W-1:0]  bus_bm
);
    logic in_addr, in_data, own;

    assign in_addr = (st == ST_ADDR);
    assign in_data = (st == ST_DATA);
    assign own     = in_addr || in_data;

    assign ctl_oe   = own;
    assign bus_rd   = own && !cur_wr;
    assign bus_das  = !in_data;
    assign bus_xin  = in_data && !cur_wr;
    assign bus_xout = in_addr || (in_data && cur_wr);
    assign dal_oe   = in_addr || (in_data && cur_wr);
    assign dal_out  = in_addr ? cur_addr : cur_wdata;

    for (genvar g = 0; g < int'(BM_W); g++) begin : g_lane
        assign bus_bm[g] = own ? cur_mask[g] : 1'b1;
    end
endmodule

// File: rtl/mux_bus_master.sv
module mux_bus_master
    import mbm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_rel_en,
    input  logic             req_start,
    input  logic [DAL_W-1:0] req_addr,
    input  logic             req_write,
    input  logic [BM_W-1:0]  req_bytes,
    input  logic [LEN_W-1:0] req_len,
    input  logic [DAL_W-1:0] req_wdata,
    input  logic             bus_ready,
    input  logic             bus_rel,
    input  logic [DAL_W-1:0] dal_in,
    output logic [DAL_W-1:0] dal_out,
    output logic             dal_oe,
    output logic             ctl_oe,
    output logic             bus_rd,
    output logic             bus_xin,
    output logic             bus_xout,
    output logic             bus_das,
    output logic [BM_W-1:0]  bus_bm,
    output logic             busy,
    output logic             word_done,
    output logic [DAL_W-1:0] rd_data
);
    bus_state_e       st;
    logic [DAL_W-1:0] cur_addr, cur_wdata;
    logic             cur_wr;
    logic [BM_W-1:0]  cur_mask;

    mbm_seq u_seq (
        .clk(clk), .rst_n(rst_n), .cfg_rel_en(cfg_rel_en),
        .req_start(req_start), .req_addr(req_addr), .req_write(req_write),
        .req_bytes(req_bytes), .req_len(req_len), .req_wdata(req_wdata),
        .bus_ready(bus_ready), .bus_rel(bus_rel), .dal_in(dal_in),
        .st(st), .cur_addr(cur_addr), .cur_wr(cur_wr), .cur_mask(cur_mask),
        .cur_wdata(cur_wdata), .rd_data(rd_data), .word_done(word_done)
    );

    mbm_pins u_pins (
        .st(st), .cur_addr(cur_addr), .cur_wr(cur_wr), .cur_mask(cur_mask),
        .cur_wdata(cur_wdata), .dal_out(dal_out), .dal_oe(dal_oe),
        .ctl_oe(ctl_oe), .bus_rd(bus_rd), .bus_xin(bus_xin),
        .bus_xout(bus_xout), .bus_das(bus_das), .bus_bm(bus_bm)
    );

    assign busy = (st != ST_IDLE);
endmodule

// File: rtl/mbm_check.sv
module mbm_check
    import mbm_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             req_start,
    input logic [DAL_W-1:0] req_addr,
    input logic             bus_ready,
    input logic [DAL_W-1:0] dal_out,
    input logic             dal_oe,
    input logic             ctl_oe,
    input logic             bus_rd,
    input logic             bus_xin,
    input logic             bus_xout,
    input logic             bus_das,
    input logic             busy,
    input logic             word_done
);
    AST_START_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_start && !busy) |=> (ctl_oe && bus_das && dal_oe && dal_out == $past(req_addr))); // R1

    AST_RD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_oe && $past(ctl_oe)) |-> $stable(bus_rd)); // R2

    AST_XIN_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_xin |-> (bus_rd && !bus_das && !dal_oe)); // R3

    AST_XOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_oe && !bus_rd) |-> (bus_xout && dal_oe)); // R4

    AST_DONE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |-> (bus_das && !$past(bus_das))); // R5

    AST_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_oe && !bus_das && !bus_ready) |=> (ctl_oe && !bus_das)); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_oe |-> (!bus_xin && !bus_xout && !dal_oe)); // R10
endmodule

bind mux_bus_master mbm_check u_chk (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_addr(req_addr),
    .bus_ready(bus_ready), .dal_out(dal_out), .dal_oe(dal_oe),
    .ctl_oe(ctl_oe), .bus_rd(bus_rd), .bus_xin(bus_xin),
    .bus_xout(bus_xout), .bus_das(bus_das), .busy(busy),
    .word_done(word_done)
);

// File: tb/mux_bus_master_test.sv
module mux_bus_master_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_rel_en = 1'b0;
    logic        req_start = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_bytes = '0;
    logic [7:0]  req_len = '0;
    logic [15:0] req_wdata = '0;
    logic        bus_ready = 1'b0;
    logic        bus_rel = 1'b0;
    logic [15:0] dal_in = '0;
    logic [15:0] dal_out, rd_data;
    logic        dal_oe, ctl_oe, bus_rd, bus_xin, bus_xout, bus_das, busy, word_done;
    logic [1:0]  bus_bm;

    always #4 clk = ~clk;

    mux_bus_master uut (
        .clk(clk), .rst_n(rst_n), .cfg_rel_en(cfg_rel_en), .req_start(req_start),
        .req_addr(req_addr), .req_write(req_write), .req_bytes(req_bytes),
        .req_len(req_len), .req_wdata(req_wdata), .bus_ready(bus_ready),
        .bus_rel(bus_rel), .dal_in(dal_in), .dal_out(dal_out), .dal_oe(dal_oe),
        .ctl_oe(ctl_oe), .bus_rd(bus_rd), .bus_xin(bus_xin), .bus_xout(bus_xout),
        .bus_das(bus_das), .bus_bm(bus_bm), .busy(busy), .word_done(word_done),
        .rd_data(rd_data)
    );

    typedef struct {
        logic [15:0] addr;
        logic        wr;
        logic [1:0]  bm;
        logic [15:0] wdata;
    } exp_t;

    exp_t q[$];
    exp_t cur;
    int checks = 0;
    int fails = 0;
    int waits = 0;
    int rel_at = -1;
    int word_idx = 0;
    int dcyc = 0;
    int done_cnt = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    function automatic logic [15:0] rd_pat(input logic [15:0] a);
        return a ^ 16'h5A3C;
    endfunction

    // monitor: pops expected words as the bus shows them
    always @(negedge clk) begin
        if (rst_n) begin
            if (word_done) begin
                done_cnt++;
                chk(bus_das == 1'b1, "R5", "strobe high after word", bus_das, 1);
                chk(dcyc == waits + 1, "R6", "data phase length", dcyc, waits + 1);
                if (!cur.wr)
                    chk(rd_data == rd_pat(cur.addr), "R5", "captured read data", rd_data, rd_pat(cur.addr));
                if (q.size() > 0) req_wdata = q[0].wdata;
            end
            if (busy && bus_das) begin
                bus_ready = 1'b0;
                dcyc = 0;
                if (q.size() == 0) begin
                    chk(1'b0, "R8", "extra word on bus", dal_out, 0);
                end else begin
                    cur = q.pop_front();
                    chk(dal_out == cur.addr && dal_oe, "R1", "address phase", dal_out, cur.addr);
                    chk(bus_rd == !cur.wr, "R2", "read indicator", bus_rd, !cur.wr);
                    chk(bus_xout && !bus_xin, "R4", "address enables", {bus_xout, bus_xin}, 2'b10);
                    chk(bus_bm == cur.bm, "R7", "byte mask", bus_bm, cur.bm);
                    chk(ctl_oe == 1'b1, "R10", "drive enable", ctl_oe, 1);
                    dal_in = rd_pat(cur.addr);
                    bus_rel = (word_idx == rel_at);
                    word_idx++;
                end
            end else if (busy) begin
                bus_rel = 1'b0;
                dcyc++;
                if (cur.wr) begin
                    chk(bus_xout && dal_oe && !bus_xin, "R4", "write data enables", {bus_xout, dal_oe, bus_xin}, 3'b110);
                    chk(dal_out == cur.wdata, "R4", "write data value", dal_out, cur.wdata);
                end else begin
                    chk(bus_xin && !bus_xout && !dal_oe, "R3", "read data enables", {bus_xin, bus_xout, dal_oe}, 3'b100);
                end
                chk(bus_rd == !cur.wr, "R2", "indicator in data phase", bus_rd, !cur.wr);
                bus_ready = (dcyc > waits);
            end else begin
                bus_ready = 1'b0;
                bus_rel = 1'b0;
            end
        end
    end

    // driver: queues expected words, then issues the request
    task automatic run_burst(input logic [15:0] a, input bit wr, input logic [1:0] bytes,
                             input int len, input int w, input int rel, input bit rel_cfg,
                             input bit poke);
        int n;
        waits = w;
        rel_at = rel;
        word_idx = 0;
        done_cnt = 0;
        n = (rel_cfg && rel >= 0 && rel < len + 1) ? rel + 1 : len + 1;
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.addr  = a + 16'(2 * i);
            e.wr    = wr;
            e.bm    = ~bytes;
            e.wdata = 16'(a * 3) + 16'(i * 16'h0111);
            q.push_back(e);
        end
        @(negedge clk);
        cfg_rel_en = rel_cfg;
        req_addr   = a;
        req_write  = wr;
        req_bytes  = bytes;
        req_len    = 8'(len);
        req_wdata  = q[0].wdata;
        req_start  = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        if (poke) begin
            @(negedge clk);
            req_addr  = 16'hDEAD;
            req_len   = 8'd9;
            req_start = 1'b1;
            @(negedge clk);
            req_start = 1'b0;
        end
        while (busy) @(negedge clk);
        @(negedge clk);
        chk(q.size() == 0, rel_cfg ? "R9" : "R8", "words left unissued", q.size(), 0);
        chk(done_cnt == n, poke ? "R11" : "R8", "word count", done_cnt, n);
        chk(!ctl_oe && !dal_oe && !bus_xin && !bus_xout, "R10", "idle enables",
            {ctl_oe, dal_oe, bus_xin, bus_xout}, 0);
        q.delete();
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "WD", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !ctl_oe && !dal_oe && !word_done, "R10", "reset state",
            {busy, ctl_oe, dal_oe, word_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_burst(16'h1000, 1'b1, 2'b11, 0, 0, -1, 1'b0, 1'b0); // R1 R4 R7 whole word write
        run_burst(16'h2040, 1'b0, 2'b10, 3, 2, -1, 1'b0, 1'b0); // R3 R6 upper byte read
        run_burst(16'h3FFC, 1'b1, 2'b01, 4, 1, -1, 1'b0, 1'b1); // R11 lower byte, start while busy
        run_burst(16'h0100, 1'b0, 2'b00, 2, 0, -1, 1'b0, 1'b0); // R7 no byte
        run_burst(16'h4000, 1'b1, 2'b11, 5, 1,  1, 1'b1, 1'b0); // R9 release mid burst
        run_burst(16'h5000, 1'b0, 2'b11, 3, 0,  1, 1'b0, 1'b0); // R9 release disabled
        run_burst(16'h6000, 1'b0, 2'b11, 6, 3,  0, 1'b1, 1'b0); // R9 release on first word
        run_burst(16'h7000, 1'b0, 2'b11, 6, 3,  2, 1'b1, 1'b0); // R9 R6 release, wait states
        finish_run();
    end
endmodule